// File: doc/BRIEF.md
# Flash Operation Busy and Status Reporter

This block holds the completion status of an embedded program or erase run inside a flash device. When the command logic launches an operation, the block times it with a cycle counter whose length depends on the operation kind. While the operation runs, the block takes over the read path. Bit 7 carries a data-polling flag: a read of the byte being programmed returns that byte's bit 7 inverted. Bit 6 carries a toggle flag that flips after every completed read access. All other bits pass through from the array.

A host can use either method to learn when the device is free. It can compare bit 7 with the value it wrote, or it can read twice and see whether bit 6 still moves. When the timer expires, a one-cycle done pulse is raised, busy falls, and every read returns plain array data again. A new operation may be launched from that cycle on. The array storage and the command sequence decoder sit outside this block.

Top module: `flash_busy_status`

## Requirements
- R1: After synchronous reset, busy and done are low and rd_data equals arr_data on all eight bits.
- R2: A start pulse taken while idle with op_kind 0 (byte program), 1 (sector erase) or 2 (chip erase) raises busy on the next cycle. Busy then stays high for exactly PROG_CYCLES, SECT_CYCLES or CHIP_CYCLES cycles respectively.
- R3: done is high for one cycle only, in the first cycle in which busy is low after an operation, and at no other time.
- R4: A start pulse while busy, or with op_kind 3 at any time, is ignored: busy, its remaining duration and the latched address and data stay as they were.
- R5: During a byte program, a read whose rd_addr equals the prog_addr latched at start returns the inverse of the latched prog_msb on bit 7.
- R6: During a byte program, a read of any other address returns the array's bit 7 on bit 7. During either erase kind, bit 7 reads 0.
- R7: While busy, bit 6 of rd_data shows a toggle flag that is cleared by reset. The flag inverts once for each falling edge of rd_en seen while busy, whatever the address, and holds its value otherwise.
- R8: While busy, bits 5 to 0 of rd_data equal arr_data bits 5 to 0.
- R9: While busy is low, rd_data equals arr_data on all bits.
- R10: Reset during an operation ends it at once: on the next cycle busy is low, no done pulse appears, and reads return array data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; aborts a running operation |
| start | input | 1 | One-cycle launch request from the command decoder |
| op_kind | input | 2 | 0 program, 1 sector erase, 2 chip erase, 3 none |
| prog_addr | input | AW | Address of the byte being programmed |
| prog_msb | input | 1 | Bit 7 of the byte being programmed |
| rd_en | input | 1 | Read access strobe; an access ends on its falling edge |
| rd_addr | input | AW | Read address |
| arr_data | input | 8 | Array output for rd_addr |
| rd_data | output | 8 | Read data, status-overridden while busy |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the block with AW of 8 and with durations of 5, 9 and 14 cycles for program, sector erase and chip erase. With these values, every operation kind runs to completion many times within a short run. The short windows let the bench launch a start in the same cycle as a done pulse, issue stray starts in the middle of an operation, and trigger a reset partway through a chip erase. The distinct lengths mean that a counter loaded with the wrong duration shows up as a busy window of the wrong length.

// File: rtl/flash_stat_pkg.sv
package flash_stat_pkg;

    localparam int DATA_W   = 8;
    localparam int POLL_BIT = 7;
    localparam int TGL_BIT  = 6;

    typedef enum logic [1:0] {
        OP_PROG = 2'd0,
        OP_SECT = 2'd1,
        OP_CHIP = 2'd2,
        OP_NONE = 2'd3
    } op_kind_e;

    // Context captured when an operation is launched (address kept apart,
    // since its width is a parameter of the top).
    typedef struct packed {
        op_kind_e kind;
        logic     msb;
    } op_ctx_t;

    function automatic logic op_valid(input op_kind_e k);
        return (k != OP_NONE);
    endfunction

    function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                         input int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

    // Status byte shown while an operation runs.
    function automatic logic [DATA_W-1:0] status_byte(input logic [DATA_W-1:0] arr,
                                                      input op_ctx_t ctx,
                                                      input logic hit,
                                                      input logic tgl);
        logic [DATA_W-1:0] b;
        b = arr;
        b[TGL_BIT] = tgl;
        if (ctx.kind == OP_PROG)
            b[POLL_BIT] = hit ? ~ctx.msb : arr[POLL_BIT];
        else
            b[POLL_BIT] = 1'b0;
        return b;
    endfunction

endpackage

// File: rtl/fbs_op_timer.sv
module fbs_op_timer
    import flash_stat_pkg::*;
#(
    parameter int unsigned PROG_CYCLES = 6250,
    parameter int unsigned SECT_CYCLES = 1250000000,
    parameter int unsigned CHIP_CYCLES = 1250000000
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     launch,
    input  op_kind_e kind,
    output logic     busy,
    output logic     done
);

    localparam int unsigned LONGEST = max3(PROG_CYCLES, SECT_CYCLES, CHIP_CYCLES);
    localparam int          CW      = (LONGEST > 1) ? $clog2(LONGEST) : 1;

    logic [CW-1:0] left_q;

    function automatic logic [CW-1:0] load_for(input op_kind_e k);
        case (k)
            OP_PROG: return CW'(PROG_CYCLES - 1);
            OP_SECT: return CW'(SECT_CYCLES - 1);
            OP_CHIP: return CW'(CHIP_CYCLES - 1);
            default: return '0;
        endcase
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b0;
            done   <= 1'b0;
            left_q <= '0;
        end else begin
            done <= 1'b0;
            if (busy) begin
                if (left_q == '0) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end else begin
                    left_q <= left_q - 1'b1;
                end
            end else if (launch) begin
                busy   <= 1'b1;
                left_q <= load_for(kind);
            end
        end
    end

endmodule

// File: rtl/fbs_toggle_track.sv
module fbs_toggle_track (
    input  logic clk,
    input  logic rst,
    input  logic rd_en,
    input  logic busy,
    output logic tgl
);

    logic rd_q;
    logic access_end;

    assign access_end = rd_q & ~rd_en;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q <= 1'b0;
            tgl  <= 1'b0;
        end else begin
            rd_q <= rd_en;
            if (access_end && busy)
                tgl <= ~tgl;
        end
    end

endmodule

// File: rtl/fbs_read_mux.sv
module fbs_read_mux
    import flash_stat_pkg::*;
(
    input  logic              busy,
    input  op_ctx_t           ctx,
    input  logic              hit,
    input  logic              tgl,
    input  logic [DATA_W-1:0] arr_data,
    output logic [DATA_W-1:0] rd_data
);

    always_comb begin
        if (busy)
            rd_data = status_byte(arr_data, ctx, hit, tgl);
        else
            rd_data = arr_data;
    end

endmodule

// File: rtl/flash_busy_status.sv
module flash_busy_status
    import flash_stat_pkg::*;
#(
    parameter int          AW          = 17,
    parameter int unsigned PROG_CYCLES = 6250,
    parameter int unsigned SECT_CYCLES = 1250000000,
    parameter int unsigned CHIP_CYCLES = 1250000000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [1:0]        op_kind,
    input  logic [AW-1:0]     prog_addr,
    input  logic              prog_msb,
    input  logic              rd_en,
    input  logic [AW-1:0]     rd_addr,
    input  logic [DATA_W-1:0] arr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              busy,
    output logic              done
);

    op_kind_e      kind_in;
    logic          launch;
    op_ctx_t       ctx_q;
    logic [AW-1:0] addr_q;
    logic          hit;
    logic          tgl;

    assign kind_in = op_kind_e'(op_kind);
    assign launch  = start & ~busy & op_valid(kind_in);
    assign hit     = (rd_addr == addr_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctx_q  <= '{kind: OP_NONE, msb: 1'b0};
            addr_q <= '0;
        end else if (launch) begin
            ctx_q  <= '{kind: kind_in, msb: prog_msb};
            addr_q <= prog_addr;
        end
    end

    fbs_op_timer #(
        .PROG_CYCLES (PROG_CYCLES),
        .SECT_CYCLES (SECT_CYCLES),
        .CHIP_CYCLES (CHIP_CYCLES)
    ) u_timer (
        .clk    (clk),
        .rst    (rst),
        .launch (launch),
        .kind   (kind_in),
        .busy   (busy),
        .done   (done)
    );

    fbs_toggle_track u_toggle (
        .clk   (clk),
        .rst   (rst),
        .rd_en (rd_en),
        .busy  (busy),
        .tgl   (tgl)
    );

    fbs_read_mux u_mux (
        .busy     (busy),
        .ctx      (ctx_q),
        .hit      (hit),
        .tgl      (tgl),
        .arr_data (arr_data),
        .rd_data  (rd_data)
    );

endmodule

// File: rtl/flash_busy_status_chk.sv
module flash_busy_status_chk (
    input logic       clk,
    input logic       rst,
    input logic       start,
    input logic       rd_en,
    input logic [7:0] arr_data,
    input logic [7:0] rd_data,
    input logic       busy,
    input logic       done
);

    // R2
    busy_from_start_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !$past(busy)) |-> $past(start));

    // R3
    done_at_end_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> ($past(busy) && !busy));

    // R3
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R7
    toggle_flip_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(rd_en) && !rd_en) |=> (!busy || rd_data[6] != $past(rd_data[6])));

    // R8
    low_bits_pass_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> (rd_data[5:0] == arr_data[5:0]));

    // R9
    idle_pass_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (rd_data == arr_data));

    // R10
    reset_abort_chk: assert property (@(posedge clk)
        rst |=> (!busy && !done));

endmodule

bind flash_busy_status flash_busy_status_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .rd_en    (rd_en),
    .arr_data (arr_data),
    .rd_data  (rd_data),
    .busy     (busy),
    .done     (done)
);

// File: tb/flash_busy_status_tb.sv
module flash_busy_status_tb;

    localparam int AW = 8;
    localparam int NP = 5;
    localparam int NS = 9;
    localparam int NC = 14;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [1:0]    op_kind = 2'd0;
    logic [AW-1:0] prog_addr = '0;
    logic          prog_msb = 1'b0;
    logic          rd_en = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic [7:0]    arr_data;
    logic [7:0]    rd_data;
    logic          busy, done;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    function automatic logic [7:0] arr_fn(input logic [AW-1:0] a);
        return 8'(a * 8'd37) ^ 8'h5A;
    endfunction
    assign arr_data = arr_fn(rd_addr);

    flash_busy_status #(
        .AW(AW), .PROG_CYCLES(NP), .SECT_CYCLES(NS), .CHIP_CYCLES(NC)
    ) u_dut (
        .clk(clk), .rst(rst), .start(start), .op_kind(op_kind),
        .prog_addr(prog_addr), .prog_msb(prog_msb), .rd_en(rd_en),
        .rd_addr(rd_addr), .arr_data(arr_data), .rd_data(rd_data),
        .busy(busy), .done(done)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Behavioural reference model
    bit        m_busy = 0, m_done = 0, m_tgl = 0, m_rdq = 0, m_msb = 0;
    int        m_left = 0, m_kind = 3;
    int        m_addr = 0;
    int        run_len = 0, last_len = 0, done_cnt = 0;

    always @(posedge clk) begin
        if (rst) begin
            m_busy = 0; m_done = 0; m_tgl = 0; m_rdq = 0; m_left = 0;
        end else begin
            if (m_rdq && !rd_en && m_busy) m_tgl = !m_tgl;
            m_rdq = rd_en;
            m_done = 0;
            if (m_busy) begin
                if (m_left == 1) begin m_busy = 0; m_done = 1; end
                else m_left = m_left - 1;
            end else if (start && op_kind != 2'd3) begin
                m_busy = 1;
                m_kind = op_kind;
                m_left = (op_kind == 0) ? NP : (op_kind == 1) ? NS : NC;
                m_addr = prog_addr;
                m_msb  = prog_msb;
            end
        end
    end

    always @(negedge clk) begin
        logic [7:0] exp;
        string tag;
        exp = arr_data;
        if (m_busy) begin
            exp[6] = m_tgl;
            if (m_kind == 0) exp[7] = (int'(rd_addr) == m_addr) ? !m_msb : arr_data[7];
            else exp[7] = 1'b0;
        end
        if (!m_busy) tag = "R9";
        else if (rd_data[7] != exp[7]) tag = (m_kind == 0 && int'(rd_addr) == m_addr) ? "R5" : "R6";
        else if (rd_data[6] != exp[6]) tag = "R7";
        else tag = "R8";
        chk(rd_data === exp, tag, rd_data, exp);
        chk(busy === m_busy, "R2 busy", busy, m_busy);
        chk(done === m_done, "R3 done", done, m_done);
        if (busy === 1'b1) run_len++;
        else if (run_len != 0) begin last_len = run_len; run_len = 0; end
        if (done === 1'b1) done_cnt++;
        if (rst) run_len = 0;
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic launch_op(input logic [1:0] k, input logic [AW-1:0] a, input logic b);
        start = 1'b1; op_kind = k; prog_addr = a; prog_msb = b;
        step(1);
        start = 1'b0;
    endtask

    task automatic read_at(input logic [AW-1:0] a, input int n);
        rd_en = 1'b1; rd_addr = a;
        step(n);
        rd_en = 1'b0;
        step(1);
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 100 && busy === 1'b1; i++) step(1);
    endtask

    initial begin
        step(4);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(busy === 1'b0 && done === 1'b0, "R1 flags", {busy, done}, 0);
        chk(rd_data === arr_data, "R1 data", rd_data, arr_data);
        step(1);

        // R2 / R5 / R7: program with msb 1
        launch_op(2'd0, 8'h21, 1'b1);
        @(negedge clk);
        chk(busy === 1'b1, "R2 rise", busy, 1);
        step(0);
        read_at(8'h21, 1);
        @(negedge clk);
        rd_addr = 8'h21;
        #1 chk(rd_data[7] === 1'b0, "R5 poll", rd_data[7], 0);
        read_at(8'h40, 1);
        wait_idle();
        step(2);
        chk(last_len == NP, "R2 prog length", last_len, NP);

        // R4: stray starts during a program with msb 0
        done_cnt = 0;
        launch_op(2'd0, 8'h33, 1'b0);
        launch_op(2'd2, 8'h11, 1'b1);
        read_at(8'h33, 1);
        wait_idle();
        step(2);
        chk(last_len == NP, "R4 ignored start", last_len, NP);
        chk(done_cnt == 1, "R3 one pulse", done_cnt, 1);

        // R4: op kind 3 while idle
        launch_op(2'd3, 8'h05, 1'b1);
        @(negedge clk);
        chk(busy === 1'b0, "R4 kind3", busy, 0);
        step(1);

        // R6 / R7: sector erase with reads across addresses
        launch_op(2'd1, 8'h10, 1'b1);
        for (int i = 0; i < 3; i++) read_at(8'(i * 7 + 1), 1);
        wait_idle();
        step(2);
        chk(last_len == NS, "R2 sector length", last_len, NS);

        // Chip erase, then a start in the done cycle
        launch_op(2'd2, 8'h00, 1'b0);
        read_at(8'h80, 2);
        read_at(8'h81, 1);
        while (done !== 1'b1) step(1);
        launch_op(2'd0, 8'h44, 1'b1);
        @(negedge clk);
        chk(last_len == NC, "R2 chip length", last_len, NC);
        chk(busy === 1'b1, "R3 back to back", busy, 1);
        step(0);
        read_at(8'h44, 1);
        wait_idle();
        step(2);

        // R10: reset part way through a chip erase
        done_cnt = 0;
        launch_op(2'd2, 8'h00, 1'b0);
        step(5);
        rst = 1'b1;
        step(1);
        rst = 1'b0;
        @(negedge clk);
        chk(busy === 1'b0, "R10 abort", busy, 0);
        chk(rd_data === arr_data, "R10 data", rd_data, arr_data);
        step(NC + 2);
        chk(done_cnt == 0, "R10 no done", done_cnt, 0);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule